// File: doc/BRIEF.md
# Machine Cycle Phase Generator

This block sets the pace of a microcoded processor core. From one oscillator clock it produces a phase clock with one period per machine cycle, a pulse when each machine cycle begins, a pulse at the falling edge of the phase clock, and an address strobe with its output enable. The length of a machine cycle depends on what the cycle does. A plain internal operation takes five oscillator cycles. A microcode branch or an internally decoded I/O command takes six. An external bus transaction takes at least five and grows by one oscillator cycle for each cycle in which the external device withholds ready.

The microcode sequencer presents a two-bit cycle-type code before each cycle begins. The block captures the code at the edge that starts the cycle. Ready inputs are sampled only in the final base position of the cycle types that honour them, so wait states always extend the low part of the phase clock and never its high part. When DMA-pause or hold-acknowledge is asserted, the block abandons the current cycle. The phase clock then sits high and the address strobe is released to high impedance. Once both are released, a fresh machine cycle begins.

Top module: `mcyc_phase_gen`

## Requirements
- R1: While rst is high, phase_clk_n_o is 1 and cyc_start_o, ufield_launch_o, addr_stb_o and addr_stb_oe_o are 0. The first clock edge with rst low and both pause_n_i and hold_ack_n_i high starts a machine cycle, so cyc_start_o is 1 in the following oscillator cycle.
- R2: Number the oscillator cycles of a machine cycle k = 0, 1, 2, and so on. phase_clk_n_o is 1 for k = 0 and 1, and 0 for every later k, including wait states. cyc_start_o is 1 exactly when k = 0.
- R3: ufield_launch_o is 1 only at k = 2, the first oscillator cycle in which phase_clk_n_o is low.
- R4: An external bus cycle (code 2'b00) lasts 5 + n oscillator cycles. Here n is the number of consecutive edges, starting with the edge that ends k = 4, at which ext_rdy_n_i is sampled high. io_rdy_n_i has no effect on it.
- R5: An internal plain cycle (code 2'b01) lasts exactly 5 oscillator cycles, whatever ext_rdy_n_i and io_rdy_n_i do.
- R6: An internal branch cycle (code 2'b10) lasts exactly 6 oscillator cycles, whatever ext_rdy_n_i and io_rdy_n_i do.
- R7: An internal I/O command cycle (code 2'b11) lasts 6 + n oscillator cycles. Here n is the number of consecutive edges, starting with the edge that ends k = 5, at which io_rdy_n_i is sampled high. ext_rdy_n_i has no effect on it.
- R8: cyc_type_i is captured at the edge that begins a machine cycle. Changes to it at any later point in that cycle have no effect on its length or its strobes.
- R9: addr_stb_o is 1 only at k = 0 of an external bus cycle. It is 0 for the whole of every internal cycle. addr_stb_oe_o is 1 throughout every machine cycle.
- R10: From the oscillator cycle after an edge at which pause_n_i or hold_ack_n_i is low, and for as long as that lasts, phase_clk_n_o is 1 and addr_stb_oe_o, addr_stb_o, cyc_start_o and ufield_launch_o are 0. The interrupted cycle is abandoned.
- R11: The first edge after a freeze at which pause_n_i and hold_ack_n_i are both high starts a new machine cycle at k = 0, with the cycle type captured at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_type_i | input | 2 | Cycle-type code: 00 external, 01 internal plain, 10 branch, 11 internal I/O command |
| ext_rdy_n_i | input | 1 | Active-low ready from external memory or I/O |
| io_rdy_n_i | input | 1 | Active-low ready for internally decoded I/O commands |
| pause_n_i | input | 1 | Active-low DMA pause |
| hold_ack_n_i | input | 1 | Active-low hold acknowledge |
| phase_clk_n_o | output | 1 | Phase clock, high for the first two oscillator cycles of a machine cycle |
| cyc_start_o | output | 1 | One-cycle pulse at k = 0 |
| ufield_launch_o | output | 1 | One-cycle pulse at the phase-clock falling edge |
| addr_stb_o | output | 1 | Address strobe |
| addr_stb_oe_o | output | 1 | Output enable of the address strobe |

## Verification
The bench measures the period between cycle starts for every cycle type. It runs zero to three external wait states and zero to two I/O wait states. A design that sampled ready in the wrong position, or that stretched the high phase, would show a wrong period or a misplaced launch pulse. Each internal type runs with both ready inputs held not-ready, which catches a design that lets the wrong ready stall a cycle. The bench also changes the type code in the middle of a cycle; a design that did not hold the captured type would change length there. Freezes by pause and by hold are entered in the middle of a cycle. A wrong design would leave the strobe enabled, let the phase clock drop, or fail to restart at k = 0 on release.

// File: rtl/mcyc_pkg.sv
`timescale 1ns/1ps
package mcyc_pkg;
  typedef enum logic [1:0] {
    CYC_EXT    = 2'b00,
    CYC_INT    = 2'b01,
    CYC_BRANCH = 2'b10,
    CYC_XIO    = 2'b11
  } cyc_kind_e;
endpackage

// File: rtl/mcyc_len_sel.sv
`timescale 1ns/1ps
module mcyc_len_sel
  import mcyc_pkg::*;
#(
  parameter int BASE_LEN = 5,
  parameter int LONG_LEN = 6,
  parameter int POS_W    = 3
) (
  input  cyc_kind_e        kind_i,
  input  logic             ext_rdy_n_i,
  input  logic             io_rdy_n_i,
  output logic [POS_W-1:0] last_pos_o,
  output logic             stall_o
);
  localparam logic [POS_W-1:0] BASE_LAST = POS_W'(BASE_LEN - 1);
  localparam logic [POS_W-1:0] LONG_LAST = POS_W'(LONG_LEN - 1);

  // Final base position and the ready that may stretch it, per cycle type
  always_comb begin
    unique case (kind_i)
      CYC_EXT: begin
        last_pos_o = BASE_LAST;
        stall_o    = ext_rdy_n_i;
      end
      CYC_INT: begin
        last_pos_o = BASE_LAST;
        stall_o    = 1'b0;
      end
      CYC_BRANCH: begin
        last_pos_o = LONG_LAST;
        stall_o    = 1'b0;
      end
      default: begin
        last_pos_o = LONG_LAST;
        stall_o    = io_rdy_n_i;
      end
    endcase
  end
endmodule

// File: rtl/mcyc_seq.sv
`timescale 1ns/1ps
module mcyc_seq
  import mcyc_pkg::*;
#(
  parameter int POS_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frz_req_i,
  input  cyc_kind_e        kind_i,
  input  logic [POS_W-1:0] last_pos_i,
  input  logic             stall_i,
  output cyc_kind_e        kind_q_o,
  output cyc_kind_e        kind_d_o,
  output logic [POS_W-1:0] pos_d_o,
  output logic             frz_d_o
);
  logic [POS_W-1:0] pos_q;
  logic             frz_q;
  cyc_kind_e        kind_q;
  logic             at_last;
  logic             cyc_end;

  assign at_last  = (pos_q == last_pos_i);
  assign cyc_end  = at_last && !stall_i;
  assign kind_q_o = kind_q;

  always_comb begin
    pos_d_o  = pos_q;
    frz_d_o  = frz_q;
    kind_d_o = kind_q;
    if (frz_req_i) begin
      frz_d_o = 1'b1;
      pos_d_o = '0;
    end else if (frz_q || cyc_end) begin
      frz_d_o  = 1'b0;
      pos_d_o  = '0;
      kind_d_o = kind_i;
    end else if (!at_last) begin
      pos_d_o = pos_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q  <= '0;
      frz_q  <= 1'b1;
      kind_q <= CYC_INT;
    end else begin
      pos_q  <= pos_d_o;
      frz_q  <= frz_d_o;
      kind_q <= kind_d_o;
    end
  end

  AST_POS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    !frz_q |-> (pos_q <= last_pos_i)); // R4
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!frz_q && !frz_req_i && at_last && stall_i) |=> (pos_q == $past(pos_q) && !frz_q)); // R4
  AST_KIND_HELD: assert property (@(posedge clk) disable iff (rst)
    (!frz_q && !frz_req_i && !cyc_end) |=> $stable(kind_q)); // R8
  AST_FREEZE_ENTER: assert property (@(posedge clk) disable iff (rst)
    frz_req_i |=> frz_q); // R10
  AST_RESTART_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (frz_q && !frz_req_i) |=> (!frz_q && pos_q == '0)); // R11
endmodule

// File: rtl/mcyc_out_reg.sv
`timescale 1ns/1ps
module mcyc_out_reg
  import mcyc_pkg::*;
#(
  parameter int POS_W    = 3,
  parameter int HIGH_LEN = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [POS_W-1:0] pos_d_i,
  input  cyc_kind_e        kind_d_i,
  input  logic             frz_d_i,
  output logic             phase_clk_n_o,
  output logic             cyc_start_o,
  output logic             ufield_launch_o,
  output logic             addr_stb_o,
  output logic             addr_stb_oe_o
);
  localparam logic [POS_W-1:0] FALL_POS = POS_W'(HIGH_LEN);

  // Outputs are decoded from the next state, so each flop shows the current position
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_clk_n_o   <= 1'b1;
      cyc_start_o     <= 1'b0;
      ufield_launch_o <= 1'b0;
      addr_stb_o      <= 1'b0;
      addr_stb_oe_o   <= 1'b0;
    end else begin
      phase_clk_n_o   <= frz_d_i || (pos_d_i < FALL_POS);
      cyc_start_o     <= !frz_d_i && (pos_d_i == '0);
      ufield_launch_o <= !frz_d_i && (pos_d_i == FALL_POS);
      addr_stb_o      <= !frz_d_i && (pos_d_i == '0) && (kind_d_i == CYC_EXT);
      addr_stb_oe_o   <= !frz_d_i;
    end
  end

  AST_STB_NEEDS_OE: assert property (@(posedge clk) disable iff (rst)
    addr_stb_o |-> addr_stb_oe_o); // R9
  AST_START_IN_HIGH: assert property (@(posedge clk) disable iff (rst)
    cyc_start_o |-> phase_clk_n_o); // R2
  AST_LAUNCH_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    ufield_launch_o |-> (!phase_clk_n_o && $past(phase_clk_n_o))); // R3
  AST_FROZEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !addr_stb_oe_o |-> (phase_clk_n_o && !cyc_start_o && !ufield_launch_o && !addr_stb_o)); // R10
endmodule

// File: rtl/mcyc_phase_gen.sv
`timescale 1ns/1ps
module mcyc_phase_gen
  import mcyc_pkg::*;
#(
  parameter int BASE_LEN = 5,
  parameter int LONG_LEN = 6,
  parameter int HIGH_LEN = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cyc_type_i,
  input  logic       ext_rdy_n_i,
  input  logic       io_rdy_n_i,
  input  logic       pause_n_i,
  input  logic       hold_ack_n_i,
  output logic       phase_clk_n_o,
  output logic       cyc_start_o,
  output logic       ufield_launch_o,
  output logic       addr_stb_o,
  output logic       addr_stb_oe_o
);
  localparam int POS_W = $clog2(LONG_LEN);

  generate
    if (HIGH_LEN < 1 || HIGH_LEN >= BASE_LEN - 1 || LONG_LEN < BASE_LEN) begin : g_bad_cfg
      $error("mcyc_phase_gen: inconsistent cycle lengths");
    end
  endgenerate

  logic             frz_req;
  cyc_kind_e        kind_q;
  cyc_kind_e        kind_d;
  logic [POS_W-1:0] pos_d;
  logic             frz_d;
  logic [POS_W-1:0] last_pos;
  logic             stall;

  assign frz_req = !pause_n_i || !hold_ack_n_i;

  mcyc_len_sel #(
    .BASE_LEN (BASE_LEN),
    .LONG_LEN (LONG_LEN),
    .POS_W    (POS_W)
  ) i_len_sel (
    .kind_i      (kind_q),
    .ext_rdy_n_i (ext_rdy_n_i),
    .io_rdy_n_i  (io_rdy_n_i),
    .last_pos_o  (last_pos),
    .stall_o     (stall)
  );

  mcyc_seq #(
    .POS_W (POS_W)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .frz_req_i  (frz_req),
    .kind_i     (cyc_kind_e'(cyc_type_i)),
    .last_pos_i (last_pos),
    .stall_i    (stall),
    .kind_q_o   (kind_q),
    .kind_d_o   (kind_d),
    .pos_d_o    (pos_d),
    .frz_d_o    (frz_d)
  );

  mcyc_out_reg #(
    .POS_W    (POS_W),
    .HIGH_LEN (HIGH_LEN)
  ) i_out_reg (
    .clk             (clk),
    .rst             (rst),
    .pos_d_i         (pos_d),
    .kind_d_i        (kind_d),
    .frz_d_i         (frz_d),
    .phase_clk_n_o   (phase_clk_n_o),
    .cyc_start_o     (cyc_start_o),
    .ufield_launch_o (ufield_launch_o),
    .addr_stb_o      (addr_stb_o),
    .addr_stb_oe_o   (addr_stb_oe_o)
  );

  AST_PAUSE_FREEZES: assert property (@(posedge clk) disable iff (rst)
    frz_req |=> (phase_clk_n_o && !addr_stb_oe_o)); // R10
  AST_INTERNAL_NO_STB: assert property (@(posedge clk) disable iff (rst)
    (kind_q != CYC_EXT) |-> !addr_stb_o); // R9
endmodule

// File: tb/test_mcyc_phase_gen.sv
`timescale 1ns/1ps
module test_mcyc_phase_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cyc_type = 2'b01;
  logic       ext_rdy_n = 1'b0;
  logic       io_rdy_n = 1'b0;
  logic       pause_n = 1'b1;
  logic       hold_ack_n = 1'b1;
  logic       phase_clk_n, cyc_start, ufield_launch, addr_stb, addr_stb_oe;
  int         n_chk = 0;
  int         n_fail = 0;

  always #2.5 clk = ~clk;

  mcyc_phase_gen i_mcyc_phase_gen (
    .clk             (clk),
    .rst             (rst),
    .cyc_type_i      (cyc_type),
    .ext_rdy_n_i     (ext_rdy_n),
    .io_rdy_n_i      (io_rdy_n),
    .pause_n_i       (pause_n),
    .hold_ack_n_i    (hold_ack_n),
    .phase_clk_n_o   (phase_clk_n),
    .cyc_start_o     (cyc_start),
    .ufield_launch_o (ufield_launch),
    .addr_stb_o      (addr_stb),
    .addr_stb_oe_o   (addr_stb_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_start();
    int guard = 0;
    @(negedge clk);
    while (!cyc_start && guard < 60) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Runs one machine cycle of type typ; ready inputs are held high while k < *_hi
  task automatic run_cycle(input logic [1:0] typ, input int ext_hi, input int io_hi,
                           input bit flip, input logic [1:0] flip_to,
                           input int exp_len, input string req);
    int  k = 0;
    bit  done = 0;
    cyc_type = typ;
    wait_start();
    while (!done) begin
      chk(phase_clk_n == (k < 2), "R2 phase level", phase_clk_n, k < 2);
      chk(ufield_launch == (k == 2), "R3 launch pulse", ufield_launch, k == 2);
      chk(addr_stb == (typ == 2'b00 && k == 0), "R9 strobe", addr_stb, typ == 2'b00 && k == 0);
      chk(addr_stb_oe == 1'b1, "R9 strobe enable", addr_stb_oe, 1);
      if (flip && k == 1) cyc_type = flip_to;
      ext_rdy_n = (k < ext_hi);
      io_rdy_n  = (k < io_hi);
      @(negedge clk);
      k++;
      if (cyc_start || k > 40) done = 1;
    end
    chk(k == exp_len, req, k, exp_len);
    ext_rdy_n = 1'b0;
    io_rdy_n  = 1'b0;
    cyc_type  = typ;
  endtask

  task automatic freeze_case(input bit by_hold, input logic [1:0] typ);
    cyc_type = typ;
    wait_start();
    @(negedge clk);
    @(negedge clk);
    if (by_hold) hold_ack_n = 1'b0; else pause_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(phase_clk_n == 1'b1, "R10 phase held high", phase_clk_n, 1);
      chk(addr_stb_oe == 1'b0, "R10 strobe enable off", addr_stb_oe, 0);
      chk(!addr_stb && !cyc_start && !ufield_launch, "R10 strobes quiet",
          {addr_stb, cyc_start, ufield_launch}, 0);
    end
    hold_ack_n = 1'b1;
    pause_n    = 1'b1;
    @(negedge clk);
    chk(cyc_start == 1'b1, "R11 restart at k=0", cyc_start, 1);
    chk(addr_stb == (typ == 2'b00), "R11 strobe on restart", addr_stb, typ == 2'b00);
    chk(addr_stb_oe == 1'b1, "R11 enable on restart", addr_stb_oe, 1);
  endtask

  task automatic reset_case();
    @(negedge clk);
    chk(phase_clk_n == 1'b1, "R1 reset phase", phase_clk_n, 1);
    chk({cyc_start, ufield_launch, addr_stb, addr_stb_oe} == 4'b0, "R1 reset strobes",
        {cyc_start, ufield_launch, addr_stb, addr_stb_oe}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(cyc_start == 1'b1, "R1 first cycle start", cyc_start, 1);
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    reset_case();
    for (int w = 0; w < 4; w++)
      run_cycle(2'b00, 4 + w, 99, 0, 2'b00, 5 + w, "R4 external cycle length");
    run_cycle(2'b00, 4, 99, 0, 2'b00, 5, "R4 io ready ignored on external");
    run_cycle(2'b01, 99, 99, 0, 2'b00, 5, "R5 plain cycle ignores readies");
    run_cycle(2'b10, 99, 99, 0, 2'b00, 6, "R6 branch cycle ignores readies");
    for (int w = 0; w < 3; w++)
      run_cycle(2'b11, 99, 5 + w, 0, 2'b00, 6 + w, "R7 io command cycle length");
    run_cycle(2'b10, 99, 99, 1, 2'b01, 6, "R8 type change mid branch");
    run_cycle(2'b01, 0, 0, 1, 2'b11, 5, "R8 type change mid plain");
    run_cycle(2'b00, 4, 0, 1, 2'b10, 5, "R8 type change mid external");
    freeze_case(0, 2'b00);
    freeze_case(1, 2'b01);
    freeze_case(1, 2'b10);
    run_cycle(2'b11, 99, 6, 0, 2'b00, 7, "R7 io wait after freeze");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule